// File: doc/BRIEF.md
# Word Rotate-and-Mask Unit

This unit is one stage of a 64-bit integer datapath. It rotates a 32-bit word, applies a run-of-ones mask, and writes a registered 64-bit result. It has three operations. Two of them AND the rotated value with the mask: one takes its rotate amount from an immediate field, the other from a register operand. The third merges the masked rotated value into the previous destination contents, so the mask picks which bits come from the rotation and which are kept.

The rotation works on the low 32 bits of the source. That word is copied into both halves of a 64-bit value, and the 64-bit value is rotated left, so both halves carry the same rotated word. The mask is given by a begin position and an end position, counted from the most significant bit of the low word. When begin is greater than end the mask wraps around. A wrapped mask also sets every bit of the upper half, so in that case the rotated word also appears in the upper 32 bits of the result.

A small two-state controller sequences the output. In `ST_IDLE` no result is presented. In `ST_DONE` a new result is on the output.
- Transitions out of `ST_IDLE`: `accept` (input valid) leads to `ST_DONE`; `wait` (no input valid) stays in `ST_IDLE`.
- Transitions out of `ST_DONE`: `chain` (input valid) stays in `ST_DONE`; `drain` (no input valid) returns to `ST_IDLE`.

Top module: `wrm_unit`

## Requirements
- R1: Only `src_val[31:0]` is used. It is placed in both halves of a 64-bit value, which is rotated left. `src_val[63:32]` has no effect on the result.
- R2: The rotate amount is 5 bits wide (0..31). An amount of 0 gives the duplicated word unchanged.
- R3: When `mbeg <= mend`, the mask has ones from bit 31-`mbeg` down to bit 31-`mend` and zeros everywhere else, including bits 63..32.
- R4: When `mbeg > mend`, the mask is all ones except bits 31-(`mbeg`-1) down to 31-(`mend`+1). That run is empty when `mbeg` = `mend`+1. Bits 63..32 of the mask are all ones.
- R5: With `op` = 2'b00 (immediate rotate-and-mask), the rotate amount is `imm_sh` and the result is the rotated value AND the mask.
- R6: With `op` = 2'b01 (register rotate-and-mask), the rotate amount is `amt_val[4:0]` and the result is the rotated value AND the mask. `amt_val[63:5]` has no effect.
- R7: With `op` = 2'b10 (rotate-and-insert), the rotate amount is `imm_sh` and the result is (rotated AND mask) OR (`dst_old` AND NOT mask).
- R8: With `op` = 2'b11, the result is zero and `out_valid` is still asserted.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and `result` shows that operation's value in the same cycle.
- R10: A cycle with `in_valid` low leaves `result` unchanged, and `out_valid` is low in the next cycle.
- R11: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 2 | Operation select: 00 immediate AND, 01 register AND, 10 insert, 11 unused |
| src_val | input | 64 | Source operand; the low word is rotated |
| amt_val | input | 64 | Register-supplied rotate amount (low 5 bits used) |
| dst_old | input | 64 | Previous destination value, used by insert |
| imm_sh | input | 5 | Immediate rotate amount |
| mbeg | input | 5 | Mask begin position |
| mend | input | 5 | Mask end position |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one clock edge after the edge that samples `in_valid`: one register stands between the inputs and `result`, and `out_valid` comes from the controller state, which is updated at that same edge. The bench drives inputs on the falling edge. At each rising edge a behavioural model computes the expected output from the inputs it sees, and the next falling edge compares the design's outputs with that expectation. This means every cycle, including idle and reset cycles, is checked at the one-edge latency. For idle cycles the model keeps its previous expected result, so the hold behaviour is checked in the same way.

// File: rtl/wrm_pkg.sv
package wrm_pkg;

    typedef enum logic [1:0] {
        OP_ROT_IMM = 2'b00,
        OP_ROT_REG = 2'b01,
        OP_INSERT  = 2'b10,
        OP_UNUSED  = 2'b11
    } wrm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } wrm_state_e;

endpackage

// File: rtl/wrm_rotl.sv
module wrm_rotl #(
    parameter int WORD = 32,
    parameter int SHW  = $clog2(WORD)
) (
    input  logic [WORD-1:0]   word_in,
    input  logic [SHW-1:0]    amt,
    output logic [2*WORD-1:0] rot_out
);
    localparam int DW = 2 * WORD;

    logic [DW-1:0] stage [SHW+1];

    assign stage[0] = {word_in, word_in};

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][DW-1-STEP:0], stage[k][DW-1 -: STEP]}
            : stage[k];
    end

    assign rot_out = stage[SHW];
endmodule

// File: rtl/wrm_mask.sv
module wrm_mask #(
    parameter int WORD = 32,
    parameter int SHW  = $clog2(WORD)
) (
    input  logic [SHW-1:0]    beg_pos,
    input  logic [SHW-1:0]    end_pos,
    output logic [2*WORD-1:0] mask_out
);
    logic wrap;
    logic [WORD-1:0] low_mask;

    assign wrap = (beg_pos > end_pos);

    always_comb begin
        for (int i = 0; i < WORD; i++) begin
            // position counted from the word's most significant bit
            int p;
            p = WORD - 1 - i;
            if (wrap)
                low_mask[i] = (p >= int'(beg_pos)) || (p <= int'(end_pos));
            else
                low_mask[i] = (p >= int'(beg_pos)) && (p <= int'(end_pos));
        end
    end

    assign mask_out = {{WORD{wrap}}, low_mask};
endmodule

// File: rtl/wrm_merge.sv
module wrm_merge
    import wrm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] rot_val,
    input  logic [XLEN-1:0] mask_val,
    input  logic [XLEN-1:0] dst_old,
    output logic [XLEN-1:0] merged
);
    wrm_op_e op_e;
    assign op_e = wrm_op_e'(op);

    always_comb begin
        unique case (op_e)
            OP_ROT_IMM,
            OP_ROT_REG: merged = rot_val & mask_val;
            OP_INSERT:  merged = (rot_val & mask_val) | (dst_old & ~mask_val);
            OP_UNUSED:  merged = '0;
            default:    merged = '0;
        endcase
    end
endmodule

// File: rtl/wrm_unit.sv
module wrm_unit
    import wrm_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = XLEN / 2,
    parameter int SHW  = $clog2(WORD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] amt_val,
    input  logic [XLEN-1:0] dst_old,
    input  logic [SHW-1:0]  imm_sh,
    input  logic [SHW-1:0]  mbeg,
    input  logic [SHW-1:0]  mend,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    wrm_state_e state_q, state_d;
    logic [SHW-1:0]  rot_amt;
    logic [XLEN-1:0] rot_val;
    logic [XLEN-1:0] mask_val;
    logic [XLEN-1:0] merged;

    assign rot_amt = (wrm_op_e'(op) == OP_ROT_REG) ? amt_val[SHW-1:0] : imm_sh;

    wrm_rotl #(.WORD(WORD), .SHW(SHW)) u_rotl (
        .word_in (src_val[WORD-1:0]),
        .amt     (rot_amt),
        .rot_out (rot_val)
    );

    wrm_mask #(.WORD(WORD), .SHW(SHW)) u_mask (
        .beg_pos  (mbeg),
        .end_pos  (mend),
        .mask_out (mask_val)
    );

    wrm_merge #(.XLEN(XLEN)) u_merge (
        .op       (op),
        .rot_val  (rot_val),
        .mask_val (mask_val),
        .dst_old  (dst_old),
        .merged   (merged)
    );

    // next state: accept / wait from idle, chain / drain from done
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= merged;
    end

    assign out_valid = (state_q == ST_DONE);
endmodule

// File: rtl/wrm_unit_chk.sv
module wrm_unit_chk #(
    parameter int XLEN = 64,
    parameter int SHW  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [1:0]      op,
    input logic [XLEN-1:0] dst_old,
    input logic [SHW-1:0]  mbeg,
    input logic [SHW-1:0]  mend,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    localparam int HW = XLEN / 2;

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11) |=> (result == '0 && out_valid));

    p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[1] == 1'b0 && mbeg <= mend) |=> (result[XLEN-1:HW] == '0));

    p_insert_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10 && mbeg <= mend)
            |=> (result[XLEN-1:HW] == $past(dst_old[XLEN-1:HW])));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));
endmodule

bind wrm_unit wrm_unit_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .dst_old   (dst_old),
    .mbeg      (mbeg),
    .mend      (mend),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/wrm_unit_test.sv
module wrm_unit_test;
    localparam time CLK_PER = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [63:0] src_val = '0;
    logic [63:0] amt_val = '0;
    logic [63:0] dst_old = '0;
    logic [4:0]  imm_sh = '0;
    logic [4:0]  mbeg = '0;
    logic [4:0]  mend = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R11";

    logic        exp_valid = 1'b0;
    logic [63:0] exp_res = '0;

    always #(CLK_PER / 2) clk = ~clk;

    wrm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_val(src_val), .amt_val(amt_val), .dst_old(dst_old),
        .imm_sh(imm_sh), .mbeg(mbeg), .mend(mend),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] ones_run(int hi, int lo);
        if (lo > hi) return 64'd0;
        return ((64'd1 << (hi + 1)) - 64'd1) & ~((64'd1 << lo) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_calc(logic [1:0] o, logic [63:0] s,
            logic [63:0] a, logic [63:0] d, logic [4:0] ish, logic [4:0] b, logic [4:0] e);
        logic [31:0] w;
        logic [63:0] m, r;
        int n;
        w = s[31:0];
        n = (o == 2'b01) ? int'(a[4:0]) : int'(ish);
        for (int j = 0; j < n; j++) w = {w[30:0], w[31]};
        r = {w, w};
        if (b <= e) m = ones_run(31 - int'(b), 31 - int'(e));
        else        m = ~ones_run(30 - int'(e), 32 - int'(b));
        case (o)
            2'b00, 2'b01: return r & m;
            2'b10:        return (r & m) | (d & ~m);
            default:      return 64'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) exp_res <= ref_calc(op, src_val, amt_val, dst_old, imm_sh, mbeg, mend);
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            total++;
            if (out_valid !== exp_valid || result !== exp_res) begin
                bad++;
                $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                         cur_req, out_valid, result, exp_valid, exp_res);
            end
        end
    end

    task automatic issue(string req, logic [1:0] o, logic [63:0] s, logic [63:0] a,
                         logic [63:0] d, logic [4:0] ish, logic [4:0] b, logic [4:0] e);
        @(negedge clk);
        cur_req = req;
        in_valid = 1'b1; op = o; src_val = s; amt_val = a; dst_old = d;
        imm_sh = ish; mbeg = b; mend = e;
    endtask

    task automatic idle(string req, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cur_req = req;
            in_valid = 1'b0;
            src_val = ~src_val; op = ~op; imm_sh = imm_sh + 5'd3;
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: valid=%0b result=%h expected completion", out_valid, result);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R11";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: upper source bits ignored, rotate by 4
        issue("R1", 2'b00, 64'hDEAD_BEEF_1234_5678, 64'd0, 64'd0, 5'd4, 5'd0, 5'd31);
        issue("R1", 2'b00, 64'h0000_0000_1234_5678, 64'd0, 64'd0, 5'd4, 5'd0, 5'd31);
        // R2: zero amount and maximum amount
        issue("R2", 2'b00, 64'h0000_0000_8000_0001, 64'd0, 64'd0, 5'd0, 5'd0, 5'd31);
        issue("R2", 2'b00, 64'h0000_0000_8000_0001, 64'd0, 64'd0, 5'd31, 5'd0, 5'd31);
        // R3: non-wrapped masks, single bit and partial run
        issue("R3", 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 5'd0, 5'd7, 5'd7);
        issue("R3", 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'd0, 5'd9, 5'd16, 5'd27);
        // R4: wrapped masks, adjacent and wide gap
        issue("R4", 2'b00, 64'h0000_0000_A5A5_5A5A, 64'd0, 64'd0, 5'd3, 5'd12, 5'd11);
        issue("R4", 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'd0, 5'd0, 5'd28, 5'd3);
        issue("R4", 2'b00, 64'h0000_0000_1357_9BDF, 64'd0, 64'd0, 5'd17, 5'd31, 5'd0);
        // R5 immediate
        issue("R5", 2'b00, 64'h0000_0000_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd13, 5'd4, 5'd20);
        // R6 register amount, upper amount bits ignored
        issue("R6", 2'b01, 64'h0000_0000_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFE7, 64'd0, 5'd2, 5'd4, 5'd20);
        issue("R6", 2'b01, 64'h0000_0000_0F0F_00FF, 64'h0000_0000_0000_0020, 64'd0, 5'd9, 5'd20, 5'd2);
        // R7 insert, plain and wrapped
        issue("R7", 2'b10, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'h1111_2222_3333_4444, 5'd8, 5'd8, 5'd15);
        issue("R7", 2'b10, 64'h0000_0000_89AB_CDEF, 64'd0, 64'h1111_2222_3333_4444, 5'd5, 5'd24, 5'd7);
        // R8 unused op
        issue("R8", 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 5'd1, 5'd0, 5'd31);
        // R9 back-to-back then R10 idle hold
        issue("R9", 2'b00, 64'h0000_0000_0000_0001, 64'd0, 64'd0, 5'd1, 5'd0, 5'd31);
        issue("R9", 2'b01, 64'h0000_0000_0000_0001, 64'd5, 64'd0, 5'd1, 5'd0, 5'd31);
        idle("R10", 4);
        // R5/R6/R7 random mix
        for (int k = 0; k < 300; k++) begin
            issue("R5/R6/R7 random", 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom}, 5'($urandom), 5'($urandom), 5'($urandom));
            if ((k % 7) == 0) idle("R10", 1);
        end
        // R11 reset while busy
        issue("R11", 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'd0, 5'd0, 5'd0, 5'd31);
        @(negedge clk);
        cur_req = "R11";
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        idle("R11", 2);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule